// File: doc/BRIEF.md
# Multi-Level Wavelet Decomposer

The block splits a vector of signed fixed-point samples into a smooth (approximation) half and a detail half using a pair of four-tap wavelet filters. After each split it runs the smooth half back through the same filter pair, down to a programmable depth of one to four levels. A typical input is the spectral signature of a single pixel, where each level halves the number of bands.

Before a run, four coefficient words are written through a small load port. Each word carries one high-pass tap in its upper half and one low-pass tap in its lower half. The words shift through a four-deep register chain. A start pulse then supplies the number of levels and the vector length. The block collects that many samples on a valid/ready input stream. Results leave on a valid/ready output stream, each tagged with its level number and a flag that tells detail from approximation. Every level emits its details first. The block then recirculates that level's approximations internally. Only the deepest level's approximations come out at the end.

Top module: `dwt_decomposer`

## Requirements
- R1: During and right after reset, `busy`, `inReady`, `outValid` and `errFlag` are low and every coefficient tap is zero.
- R2: A coefficient write is taken only while the block is idle. Each write shifts the chain, so after four writes the first word feeds tap 0 and the last feeds tap 3. Bits [31:16] are the high-pass tap and bits [15:0] the low-pass tap. A write made while busy leaves the taps unchanged.
- R3: For a level of length N, output k of either filter is the sum over taps j=0..3 of tap j times sample (2k+j) mod N of that level's vector. The indices wrap periodically at the end of the vector.
- R4: Samples and taps are signed Q2.14. The four products are summed at full width, then 2^13 is added and the sum is shifted right arithmetically by 14. The result saturates to the range -32768..32767.
- R5: A level of length N emits N/2 details in index order with `outIsDetail`=1 and `outLevel` set to the level number, starting at 1. After the details of the final level come that level's N/2 approximations with `outIsDetail`=0. No approximation of an earlier level is emitted.
- R6: The input to level n+1 is the approximation vector of level n, of half its length.
- R7: A start is rejected if the level count is outside 1..4, if the length exceeds MAX_LEN, or if any level would have an odd length or a length below 4. On rejection `errFlag` goes high and stays high until the next accepted start. No input is accepted and nothing is emitted.
- R8: `inReady` is high only while samples are being collected. Exactly `cfgLen` samples are accepted per run, after which `inReady` drops.
- R9: While `outValid` is high and `outReady` is low, `outValid`, `outData`, `outLevel` and `outIsDetail` hold their values.
- R10: A start pulse that arrives while a run is in progress has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coefValid | input | 1 | Coefficient write strobe |
| coefWord | input | 2*DATA_W | High-pass tap (upper) and low-pass tap (lower) |
| start | input | 1 | Begin a run with the given configuration |
| cfgLevels | input | LVL_W | Number of decomposition levels |
| cfgLen | input | LEN_W | Input vector length |
| inValid | input | 1 | Input sample valid |
| inReady | output | 1 | Block accepts an input sample |
| inData | input | DATA_W | Input sample, signed Q2.14 |
| outValid | output | 1 | Result valid |
| outReady | input | 1 | Consumer accepts a result |
| outData | output | DATA_W | Result, signed Q2.14 |
| outLevel | output | LVL_W | Level of the result |
| outIsDetail | output | 1 | 1 for a detail, 0 for an approximation |
| busy | output | 1 | A run is in progress |
| errFlag | output | 1 | Last start was rejected |

## Verification
The assertions watch the stream protocol on every cycle. They check that a stalled result holds, that collection never overlaps emission, that a rejected configuration leaves the block idle, that level tags stay in range and never go back down, and that no detail follows an approximation. The numerical content needs the bench's scenarios. These scenarios cover the wrap-around taps, rounding and saturation, the recirculation of approximations across levels, the order in which coefficients are loaded, and the rejected configurations.

// File: rtl/dwt_pkg.sv
package dwt_pkg;
  // Index width shared by control and datapath; bounds the largest vector.
  localparam int IDX_W = 7;
  localparam int DEPTH = 1 << IDX_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_DETAIL,
    ST_APPROX,
    ST_FINAL
  } dwt_state_e;

  // Strobes and indices passed from control to datapath.
  typedef struct packed {
    logic             coefEn;      // coefficient chain may shift
    logic             capture;     // write input sample at pos
    logic             storeApprox; // write approximation at pos into the other bank
    logic             selDetail;   // output mux picks the detail filter
    logic             readBank;    // bank holding the current level's vector
    logic [IDX_W-1:0] pos;         // sample or output pair index
    logic [IDX_W-1:0] levLen;      // length of the current level's vector
  } dwt_ctrl_t;
endpackage

// File: rtl/dwt_ctrl.sv
module dwt_ctrl
  import dwt_pkg::*;
#(
  parameter int MAX_LEN    = 64,
  parameter int MAX_LEVELS = 4,
  parameter int LEN_W      = $clog2(MAX_LEN + 1),
  parameter int LVL_W      = $clog2(MAX_LEVELS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LVL_W-1:0] cfgLevels,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic             inValid,
  input  logic             outReady,
  output logic             inReady,
  output logic             outValid,
  output logic             outIsDetail,
  output logic [LVL_W-1:0] outLevel,
  output logic             busy,
  output logic             errFlag,
  output dwt_ctrl_t        ctrl
);
  dwt_state_e       state;
  logic [IDX_W-1:0] pos;
  logic [IDX_W-1:0] curLen;
  logic [IDX_W-1:0] half;
  logic [LVL_W-1:0] level;
  logic [LVL_W-1:0] levels;
  logic             bank;
  logic             err;

  // Configuration check: every level must see an even length of at least 4.
  logic [LEN_W-1:0] lenMask;
  logic [LEN_W-1:0] lastLen;
  logic             cfgOk;

  always_comb begin
    lenMask = (LEN_W'(1) << cfgLevels) - LEN_W'(1);
    lastLen = cfgLen >> LVL_W'(cfgLevels - LVL_W'(1));
    cfgOk   = (cfgLevels >= LVL_W'(1))
           && (32'(cfgLevels) <= MAX_LEVELS)
           && (32'(cfgLen) <= MAX_LEN)
           && ((cfgLen & lenMask) == '0)
           && (lastLen >= LEN_W'(4));
  end

  assign half = curLen >> 1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      pos    <= '0;
      curLen <= '0;
      level  <= '0;
      levels <= '0;
      bank   <= 1'b0;
      err    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (cfgOk) begin
              state  <= ST_FILL;
              levels <= cfgLevels;
              curLen <= IDX_W'(cfgLen);
              level  <= LVL_W'(1);
              pos    <= '0;
              bank   <= 1'b0;
              err    <= 1'b0;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_FILL: begin
          if (inValid) begin
            if (pos == curLen - IDX_W'(1)) begin
              pos   <= '0;
              state <= ST_DETAIL;
            end else begin
              pos <= pos + IDX_W'(1);
            end
          end
        end
        ST_DETAIL: begin
          if (outReady) begin
            if (pos == half - IDX_W'(1)) begin
              pos   <= '0;
              state <= (level == levels) ? ST_FINAL : ST_APPROX;
            end else begin
              pos <= pos + IDX_W'(1);
            end
          end
        end
        ST_APPROX: begin
          if (pos == half - IDX_W'(1)) begin
            pos    <= '0;
            bank   <= ~bank;
            curLen <= half;
            level  <= level + LVL_W'(1);
            state  <= ST_DETAIL;
          end else begin
            pos <= pos + IDX_W'(1);
          end
        end
        ST_FINAL: begin
          if (outReady) begin
            if (pos == half - IDX_W'(1)) begin
              pos   <= '0;
              state <= ST_IDLE;
            end else begin
              pos <= pos + IDX_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign inReady     = (state == ST_FILL);
  assign outValid    = (state == ST_DETAIL) || (state == ST_FINAL);
  assign outIsDetail = (state == ST_DETAIL);
  assign outLevel    = level;
  assign busy        = (state != ST_IDLE);
  assign errFlag     = err;

  always_comb begin
    ctrl.coefEn      = (state == ST_IDLE);
    ctrl.capture     = (state == ST_FILL) && inValid;
    ctrl.storeApprox = (state == ST_APPROX);
    ctrl.selDetail   = (state == ST_DETAIL);
    ctrl.readBank    = bank;
    ctrl.pos         = pos;
    ctrl.levLen      = curLen;
  end
endmodule

// File: rtl/dwt_datapath.sv
module dwt_datapath
  import dwt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 14,
  parameter int TAPS   = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     coefValid,
  input  logic [2*DATA_W-1:0]      coefWord,
  input  logic signed [DATA_W-1:0] inData,
  input  dwt_ctrl_t                ctrl,
  output logic signed [DATA_W-1:0] outData
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int SUM_W  = PROD_W + $clog2(TAPS);
  localparam logic signed [SUM_W-1:0] ROUND_K = SUM_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [SUM_W-1:0] SAT_HI  = (SUM_W'(1) <<< (DATA_W - 1)) - SUM_W'(1);
  localparam logic signed [SUM_W-1:0] SAT_LO  = -(SUM_W'(1) <<< (DATA_W - 1));

  logic signed [DATA_W-1:0] loTap [TAPS];
  logic signed [DATA_W-1:0] hiTap [TAPS];
  logic signed [DATA_W-1:0] mem   [2][DEPTH];

  logic signed [DATA_W-1:0] sampleTap [TAPS];
  logic signed [PROD_W-1:0] loProd    [TAPS];
  logic signed [PROD_W-1:0] hiProd    [TAPS];
  logic signed [SUM_W-1:0]  accLo, accHi;
  logic signed [DATA_W-1:0] approxVal, detailVal;

  // Coefficient chain: a new word enters at the top tap and older words move down.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < TAPS; t++) begin
        loTap[t] <= '0;
        hiTap[t] <= '0;
      end
    end else if (coefValid && ctrl.coefEn) begin
      for (int t = 0; t < TAPS - 1; t++) begin
        loTap[t] <= loTap[t+1];
        hiTap[t] <= hiTap[t+1];
      end
      loTap[TAPS-1] <= coefWord[DATA_W-1:0];
      hiTap[TAPS-1] <= coefWord[2*DATA_W-1:DATA_W];
    end
  end

  // Ping-pong sample banks: one level reads one bank and writes its approximations to the other.
  always_ff @(posedge clk) begin
    if (ctrl.capture) mem[ctrl.readBank][ctrl.pos] <= inData;
    if (ctrl.storeApprox) mem[!ctrl.readBank][ctrl.pos] <= approxVal;
  end

  // Tap gathering with periodic wrap, one lane per tap.
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    logic [IDX_W:0]   rawIdx;
    logic [IDX_W-1:0] idx;
    assign rawIdx = {ctrl.pos, 1'b0} + (IDX_W + 1)'(t);
    assign idx    = (rawIdx >= {1'b0, ctrl.levLen})
                  ? IDX_W'(rawIdx - {1'b0, ctrl.levLen})
                  : IDX_W'(rawIdx);
    assign sampleTap[t] = mem[ctrl.readBank][idx];
    assign loProd[t]    = sampleTap[t] * loTap[t];
    assign hiProd[t]    = sampleTap[t] * hiTap[t];
  end

  always_comb begin
    accLo = '0;
    accHi = '0;
    for (int t = 0; t < TAPS; t++) begin
      accLo = accLo + SUM_W'(loProd[t]);
      accHi = accHi + SUM_W'(hiProd[t]);
    end
  end

  function automatic logic signed [DATA_W-1:0] roundSat(input logic signed [SUM_W-1:0] acc);
    logic signed [SUM_W-1:0] scaled;
    scaled = (acc + ROUND_K) >>> FRAC_W;
    if (scaled > SAT_HI)      return SAT_HI[DATA_W-1:0];
    else if (scaled < SAT_LO) return SAT_LO[DATA_W-1:0];
    else                      return scaled[DATA_W-1:0];
  endfunction

  assign approxVal = roundSat(accLo);
  assign detailVal = roundSat(accHi);
  assign outData   = ctrl.selDetail ? detailVal : approxVal;
endmodule

// File: rtl/dwt_decomposer.sv
module dwt_decomposer
  import dwt_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FRAC_W     = 14,
  parameter int MAX_LEN    = 64,
  parameter int MAX_LEVELS = 4,
  parameter int LEN_W      = $clog2(MAX_LEN + 1),
  parameter int LVL_W      = $clog2(MAX_LEVELS + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     coefValid,
  input  logic [2*DATA_W-1:0]      coefWord,
  input  logic                     start,
  input  logic [LVL_W-1:0]         cfgLevels,
  input  logic [LEN_W-1:0]         cfgLen,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic signed [DATA_W-1:0] inData,
  output logic                     outValid,
  input  logic                     outReady,
  output logic signed [DATA_W-1:0] outData,
  output logic [LVL_W-1:0]         outLevel,
  output logic                     outIsDetail,
  output logic                     busy,
  output logic                     errFlag
);
  dwt_ctrl_t ctrl;

  dwt_ctrl #(
    .MAX_LEN(MAX_LEN), .MAX_LEVELS(MAX_LEVELS), .LEN_W(LEN_W), .LVL_W(LVL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cfgLevels(cfgLevels), .cfgLen(cfgLen),
    .inValid(inValid), .outReady(outReady), .inReady(inReady), .outValid(outValid),
    .outIsDetail(outIsDetail), .outLevel(outLevel), .busy(busy), .errFlag(errFlag),
    .ctrl(ctrl)
  );

  dwt_datapath #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W), .TAPS(4)
  ) u_dp (
    .clk(clk), .rstN(rstN), .coefValid(coefValid), .coefWord(coefWord),
    .inData(inData), .ctrl(ctrl), .outData(outData)
  );
endmodule

// File: rtl/dwt_decomposer_checker.sv
module dwt_decomposer_checker #(
  parameter int DATA_W     = 16,
  parameter int MAX_LEVELS = 4,
  parameter int LVL_W      = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [DATA_W-1:0] outData,
  input logic [LVL_W-1:0]  outLevel,
  input logic              outIsDetail,
  input logic              busy,
  input logic              errFlag
);
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLevel)
                                 && $stable(outIsDetail)));

  assert_fill_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (busy && !outValid));

  assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !busy);

  assert_level_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outLevel >= LVL_W'(1) && 32'(outLevel) <= MAX_LEVELS));

  assert_approx_last_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !outIsDetail) |=> (!outValid || !outIsDetail));

  assert_level_rising_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady) |=> (!outValid || outLevel >= $past(outLevel)));
endmodule

bind dwt_decomposer dwt_decomposer_checker #(
  .DATA_W(DATA_W), .MAX_LEVELS(MAX_LEVELS), .LVL_W(LVL_W)
) u_chk (.*);

// File: tb/dwt_decomposer_test.sv
module dwt_decomposer_test;
  localparam int DATA_W = 16;
  localparam int MAX_LEN = 64;
  localparam int LEN_W = 7;
  localparam int LVL_W = 3;

  typedef struct {
    int    data;
    int    level;
    bit    detail;
    string req;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic coefValid = 1'b0;
  logic [2*DATA_W-1:0] coefWord = '0;
  logic start = 1'b0;
  logic [LVL_W-1:0] cfgLevels = '0;
  logic [LEN_W-1:0] cfgLen = '0;
  logic inValid = 1'b0;
  logic inReady;
  logic signed [DATA_W-1:0] inData = '0;
  logic outValid;
  logic outReady;
  logic signed [DATA_W-1:0] outData;
  logic [LVL_W-1:0] outLevel;
  logic outIsDetail;
  logic busy;
  logic errFlag;

  always #2.5 clk = ~clk;

  dwt_decomposer uut (
    .clk(clk), .rstN(rstN), .coefValid(coefValid), .coefWord(coefWord), .start(start),
    .cfgLevels(cfgLevels), .cfgLen(cfgLen), .inValid(inValid), .inReady(inReady),
    .inData(inData), .outValid(outValid), .outReady(outReady), .outData(outData),
    .outLevel(outLevel), .outIsDetail(outIsDetail), .busy(busy), .errFlag(errFlag)
  );

  int nChecks = 0;
  int nFails = 0;
  int readyMode = 0;
  int cyc = 0;
  item_t expQ[$];
  int lo[4];
  int hi[4];

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int roundSat(longint acc);
    longint s;
    s = (acc + 8192) >>> 14;
    if (s > 32767) return 32767;
    if (s < -32768) return -32768;
    return int'(s);
  endfunction

  function automatic int sampleOf(int pattern, int i);
    int v;
    case (pattern)
      0: v = i * 700 - 20000;
      1: begin
        v = (i * 1103515245 + 12345 + 977) >>> 7;
        v = int'($signed(v[15:0]));
      end
      2: v = 32767;
      3: v = -32768;
      default: v = (i % 2 == 0) ? 20000 : -17000;
    endcase
    return v;
  endfunction

  // Monitor: sets backpressure, compares handshaken results against the queue.
  bit stallPrev = 0;
  int stallData = 0;
  initial begin
    outReady = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      outReady = (readyMode == 0) ? 1'b1 : (cyc % 3 != 0);
      #1;
      if (stallPrev) check(outValid && int'(outData) == stallData, "R9", "held data",
                           int'(outData), stallData);
      stallPrev = outValid && !outReady;
      stallData = int'(outData);
      if (outValid && outReady) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R7", "unexpected output", int'(outData), 0);
        end else begin
          item_t e;
          e = expQ.pop_front();
          check(int'(outData) == e.data, e.req, "data", int'(outData), e.data);
          check(int'(outLevel) == e.level, "R5", "level tag", int'(outLevel), e.level);
          check(outIsDetail == e.detail, "R5", "detail flag", int'(outIsDetail), int'(e.detail));
        end
      end
    end
  end

  task automatic loadCoefs(int l[4], int h[4]);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      coefValid = 1'b1;
      coefWord = {16'(h[j]), 16'(l[j])};
    end
    @(negedge clk);
    coefValid = 1'b0;
  endtask

  task automatic waitDone();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while ((expQ.size() != 0 || busy) && guard < 5000);
    check(expQ.size() == 0, "R5", "results missing", expQ.size(), 0);
  endtask

  // Builds expected results from the requirements, then drives one run.
  task automatic runCase(int len, int lv, int pattern, string req, bit junk);
    int cur[$];
    int nxt[$];
    for (int i = 0; i < len; i++) cur.push_back(sampleOf(pattern, i));
    for (int l = 1; l <= lv; l++) begin
      int n = cur.size();
      nxt.delete();
      for (int k = 0; k < n / 2; k++) begin
        longint a = 0;
        longint d = 0;
        for (int j = 0; j < 4; j++) begin
          a += longint'(lo[j]) * cur[(2 * k + j) % n];
          d += longint'(hi[j]) * cur[(2 * k + j) % n];
        end
        expQ.push_back('{roundSat(d), l, 1'b1, req});
        nxt.push_back(roundSat(a));
      end
      if (l == lv) foreach (nxt[k]) expQ.push_back('{nxt[k], l, 1'b0, req});
      cur = nxt;
    end
    @(negedge clk);
    cfgLen = LEN_W'(len);
    cfgLevels = LVL_W'(lv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    check(errFlag == 1'b0, "R7", "error clear after good start", int'(errFlag), 0);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inData = 16'(sampleOf(pattern, i));
      if (junk) begin
        coefValid = 1'b1;
        coefWord = 32'h7FFF_7FFF;
        start = 1'b1;
        cfgLevels = 3'd1;
        cfgLen = 7'd4;
      end
      #1;
      while (!inReady) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    coefValid = 1'b0;
    start = 1'b0;
    #1;
    check(inReady == 1'b0, "R8", "ready after last sample", int'(inReady), 0);
    waitDone();
  endtask

  task automatic badStart(int len, int lv);
    @(negedge clk);
    cfgLen = LEN_W'(len);
    cfgLevels = LVL_W'(lv);
    start = 1'b1;
    inValid = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(errFlag == 1'b1, "R7", "error flag", int'(errFlag), 1);
    check(busy == 1'b0 && inReady == 1'b0, "R7", "stays idle", int'(busy), 0);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R5", "watchdog expired", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    int idl[4];
    int idh[4];
    lo = '{7913, 13706, 3672, -2120};
    for (int j = 0; j < 4; j++) hi[j] = ((j % 2 == 0) ? 1 : -1) * lo[3 - j];
    repeat (3) @(negedge clk);
    #1;
    check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    check(inReady == 1'b0, "R1", "inReady in reset", int'(inReady), 0);
    check(outValid == 1'b0, "R1", "outValid in reset", int'(outValid), 0);
    check(errFlag == 1'b0, "R1", "errFlag in reset", int'(errFlag), 0);
    @(negedge clk);
    rstN = 1'b1;

    // Zero taps straight after reset: every result must be zero (R1).
    begin
      int sl[4];
      sl = lo;
      lo = '{0, 0, 0, 0};
      hi = '{0, 0, 0, 0};
      runCase(8, 1, 0, "R1", 1'b0);
      lo = sl;
      for (int j = 0; j < 4; j++) hi[j] = ((j % 2 == 0) ? 1 : -1) * lo[3 - j];
    end

    // Tap order check with selector taps (R2).
    idl = '{16384, 0, 0, 0};
    idh = '{0, 0, 0, 16384};
    loadCoefs(idl, idh);
    begin
      int sl[4];
      int sh[4];
      sl = lo; sh = hi;
      lo = idl; hi = idh;
      runCase(8, 1, 1, "R2", 1'b0);
      lo = sl; hi = sh;
    end

    loadCoefs(lo, hi);
    runCase(8, 1, 0, "R3", 1'b0);
    runCase(16, 2, 1, "R6", 1'b0);
    readyMode = 1;
    runCase(32, 3, 4, "R6", 1'b0);
    runCase(64, 4, 1, "R6", 1'b0);
    readyMode = 0;
    runCase(4, 1, 2, "R4", 1'b0);
    runCase(4, 1, 3, "R4", 1'b0);
    // Coefficient writes and starts during a run are ignored (R2, R10).
    runCase(16, 1, 1, "R10", 1'b1);
    runCase(8, 1, 4, "R2", 1'b0);

    badStart(8, 0);
    badStart(64, 5);
    badStart(6, 2);
    badStart(8, 3);
    badStart(2, 1);
    badStart(66, 1);
    badStart(9, 1);
    runCase(16, 2, 0, "R7", 1'b0);
    repeat (5) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule